// File: doc/BRIEF.md
# IR Carrier Modulator Generator

This block produces the square-wave carrier that gates an infrared emitter. Software loads two configuration words: a control word that chooses the tick source, sets the output level used while the block is idle, and switches the carrier on, and a modulation word that holds the high-phase and low-phase lengths, counted in ticks of the chosen source. From these the block drives a carrier waveform and a single-cycle strobe that marks the end of every carrier period. Downstream pulse/space logic counts those strobes to time its marks in whole carrier periods.

Four tick sources are available: every system clock cycle, every third pulse of an externally supplied crystal-clock enable, a 1 µs tick and a 10 µs tick. The two microsecond ticks are derived inside the block from the system clock by a clock-enable divider sized from the `SYS_CLK_HZ` parameter. Each phase length is stored as its length minus one, so the carrier period in ticks is the sum of both stored values plus two, and the duty cycle is the high length over that sum. A 38 kHz, 50 % carrier is the usual setting loaded after reset.

A new modulation word is held in a shadow register while the carrier runs and moves into the active counters only when a period ends, so no phase is ever cut short. Clearing the enable bit parks the output at the idle level and returns the phase counters to the start of a high phase.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset the carrier output is 0, the period strobe is 0 and the carrier is disabled.
- R2: While control bit 0 (enable) is 0, the carrier output equals control bit 2 (idle level, 1 = high) and the period strobe stays 0.
- R3: Once enable is written to 1, the carrier goes high in the next cycle and stays high for (M+1) ticks, where M is modulation bits 31:16.
- R4: After the high phase the carrier is low for (N+1) ticks, where N is modulation bits 15:0.
- R5: The period strobe is high for exactly one cycle, in the first cycle of each new high phase, so consecutive strobes are (M+N+2) ticks apart.
- R6: Control bits 13:12 choose the tick: 0 = every system clock cycle, 1 = every third cycle in which the crystal enable input is high, 2 = every SYS_CLK_HZ/1,000,000 cycles, 3 = every ten 1 µs ticks; with source 1 and the crystal enable held low the carrier does not advance.
- R7: A modulation write while the carrier is enabled leaves the current period unchanged and takes effect from the next period.
- R8: Clearing enable returns the output to the idle level in the next cycle, and re-enabling starts a complete high phase of (M+1) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_tick_i | input | 1 | Crystal-clock enable pulse, one cycle per crystal period |
| cfg_ctrl_we | input | 1 | Write strobe for the control word |
| cfg_mod_we | input | 1 | Write strobe for the modulation word |
| cfg_wdata | input | 32 | Write data shared by both words |
| carrier_o | output | 1 | Carrier waveform |
| period_done_o | output | 1 | One-cycle strobe at each carrier period boundary |

## Verification
The bench builds the block with SYS_CLK_HZ set to 4 MHz, so the 1 µs tick arrives every 4 cycles and the 10 µs tick every 40, which keeps periods on all four sources short enough to observe several of them. With the system-clock source it sweeps every high and low length from 0 to 4 and checks both phase widths and the strobe spacing over two periods, which covers the shortest two-cycle period. It also exercises the idle levels, a mid-period reload and a disable/re-enable cycle.

// File: rtl/ir_carrier_pkg.sv
// Package: ir_carrier_pkg
// Shared encodings and field positions for the IR carrier generator.
// Assumes a 32-bit configuration write path.
package ir_carrier_pkg;

    // Width of each stored phase length (fixed by the modulation word layout)
    localparam int PHASE_W      = 16;
    // Field positions inside the control word
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_IDLE_BIT = 2;
    localparam int CTRL_SRC_LSB = 12;
    // Field positions inside the modulation word
    localparam int MOD_HI_LSB   = 16;
    localparam int MOD_LO_LSB   = 0;
    // Divider ratios
    localparam int XTAL_DIV     = 3;
    localparam int SLOW_DIV     = 10;

    typedef enum logic [1:0] {
        SRC_SYSCLK = 2'd0,
        SRC_XTAL3  = 2'd1,
        SRC_1US    = 2'd2,
        SRC_10US   = 2'd3
    } tick_src_e;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

    typedef struct packed {
        tick_src_e src;
        logic      idle_high;
        logic      en;
    } ctrl_t;

endpackage

// File: rtl/ir_us_divider.sv
// Module: ir_us_divider
// Derives a 1 us clock enable and a 10 us clock enable from the system
// clock. Assumes SYS_CLK_HZ is a whole multiple of 1 MHz; at 1 MHz or
// below the 1 us tick is asserted every cycle.
module ir_us_divider #(
    parameter int SYS_CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_1us,
    output logic tick_10us
);
    import ir_carrier_pkg::*;

    localparam int CYC_PER_US = (SYS_CLK_HZ / 1_000_000 < 1) ? 1 : SYS_CLK_HZ / 1_000_000;
    localparam int US_CNT_W   = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam int DEC_W      = $clog2(SLOW_DIV);

    logic [DEC_W-1:0] dec_cnt;

    generate
        if (CYC_PER_US > 1) begin : g_us_div
            logic [US_CNT_W-1:0] us_cnt;

            // Count system cycles within one microsecond
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    us_cnt <= '0;
                end else if (us_cnt == US_CNT_W'(CYC_PER_US - 1)) begin
                    us_cnt <= '0;
                end else begin
                    us_cnt <= us_cnt + 1'b1;
                end
            end

            assign tick_1us = (us_cnt == US_CNT_W'(CYC_PER_US - 1));
        end else begin : g_us_pass
            assign tick_1us = 1'b1;
        end
    endgenerate

    // Count microsecond ticks within ten microseconds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_cnt <= '0;
        end else if (tick_1us) begin
            if (dec_cnt == DEC_W'(SLOW_DIV - 1)) begin
                dec_cnt <= '0;
            end else begin
                dec_cnt <= dec_cnt + 1'b1;
            end
        end
    end

    assign tick_10us = tick_1us && (dec_cnt == DEC_W'(SLOW_DIV - 1));

endmodule

// File: rtl/ir_tick_select.sv
// Module: ir_tick_select
// Divides the crystal enable by XTAL_DIV and picks one of four tick
// sources for the phase counters. Assumes xtal_tick_i is already
// synchronous to clk and at most one cycle wide per crystal period.
module ir_tick_select (
    input  logic                      clk,
    input  logic                      rst_n,
    input  ir_carrier_pkg::tick_src_e src,
    input  logic                      xtal_tick_i,
    input  logic                      tick_1us,
    input  logic                      tick_10us,
    output logic                      tick
);
    import ir_carrier_pkg::*;

    localparam int XT_W = $clog2(XTAL_DIV);

    logic [XT_W-1:0] xt_cnt;
    logic            tick_xtal;

    // Count crystal enables modulo XTAL_DIV
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xt_cnt <= '0;
        end else if (xtal_tick_i) begin
            if (xt_cnt == XT_W'(XTAL_DIV - 1)) begin
                xt_cnt <= '0;
            end else begin
                xt_cnt <= xt_cnt + 1'b1;
            end
        end
    end

    assign tick_xtal = xtal_tick_i && (xt_cnt == XT_W'(XTAL_DIV - 1));

    // Route the chosen tick source to the phase counters
    always_comb begin
        unique case (src)
            SRC_SYSCLK: tick = 1'b1;
            SRC_XTAL3:  tick = tick_xtal;
            SRC_1US:    tick = tick_1us;
            SRC_10US:   tick = tick_10us;
            default:    tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/ir_phase_engine.sv
// Module: ir_phase_engine
// Runs the high/low phase counters of the carrier. While en is low it
// parks in the start of a high phase and keeps copying the shadow
// lengths; while en is high it reloads them only at a period boundary.
// Assumes lengths are stored as length minus one.
module ir_phase_engine #(
    parameter int PW = ir_carrier_pkg::PHASE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [PW-1:0] shadow_hi,
    input  logic [PW-1:0] shadow_lo,
    output logic          phase_high,
    output logic          period_done,
    output logic [PW-1:0] act_hi,
    output logic [PW-1:0] act_lo
);
    import ir_carrier_pkg::*;

    phase_e        phase;
    logic [PW-1:0] cnt;
    logic [PW-1:0] limit;
    logic          phase_end;
    logic          period_end;

    assign limit      = (phase == PH_HIGH) ? act_hi : act_lo;
    assign phase_end  = en && tick && (cnt == limit);
    assign period_end = phase_end && (phase == PH_LOW);

    // Advance the tick counter and swap phases at each phase end
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase <= PH_HIGH;
            cnt   <= '0;
        end else if (phase_end) begin
            phase <= (phase == PH_HIGH) ? PH_LOW : PH_HIGH;
            cnt   <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Load the active lengths while idle or at a period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_hi <= '0;
            act_lo <= '0;
        end else if (!en || period_end) begin
            act_hi <= shadow_hi;
            act_lo <= shadow_lo;
        end
    end

    // Raise the period strobe for the cycle after the low phase ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_done <= 1'b0;
        end else begin
            period_done <= period_end;
        end
    end

    assign phase_high = (phase == PH_HIGH);

endmodule

// File: rtl/ir_carrier_gen.sv
// Module: ir_carrier_gen
// Top of the IR carrier generator: holds the control and modulation
// words, derives the tick, runs the phase engine and drives the carrier.
// Assumes configuration writes are synchronous single-cycle strobes.
module ir_carrier_gen #(
    parameter int SYS_CLK_HZ = 100_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xtal_tick_i,
    input  logic        cfg_ctrl_we,
    input  logic        cfg_mod_we,
    input  logic [31:0] cfg_wdata,
    output logic        carrier_o,
    output logic        period_done_o
);
    import ir_carrier_pkg::*;

    ctrl_t              ctrl_q;
    logic [PHASE_W-1:0] shadow_hi;
    logic [PHASE_W-1:0] shadow_lo;
    logic [PHASE_W-1:0] act_hi_len;
    logic [PHASE_W-1:0] act_lo_len;
    logic               tick_1us;
    logic               tick_10us;
    logic               tick;
    logic               phase_high;
    logic               unused_wdata;

    assign unused_wdata = ^{cfg_wdata[31:CTRL_SRC_LSB+2],
                            cfg_wdata[CTRL_SRC_LSB-1:CTRL_IDLE_BIT+1],
                            cfg_wdata[CTRL_EN_BIT+1]};

    // Capture the control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{src: SRC_SYSCLK, idle_high: 1'b0, en: 1'b0};
        end else if (cfg_ctrl_we) begin
            ctrl_q.en        <= cfg_wdata[CTRL_EN_BIT];
            ctrl_q.idle_high <= cfg_wdata[CTRL_IDLE_BIT];
            ctrl_q.src       <= tick_src_e'(cfg_wdata[CTRL_SRC_LSB +: 2]);
        end
    end

    // Capture the modulation word into the shadow lengths
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_hi <= '0;
            shadow_lo <= '0;
        end else if (cfg_mod_we) begin
            shadow_hi <= cfg_wdata[MOD_HI_LSB +: PHASE_W];
            shadow_lo <= cfg_wdata[MOD_LO_LSB +: PHASE_W];
        end
    end

    ir_us_divider #(
        .SYS_CLK_HZ (SYS_CLK_HZ)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1us  (tick_1us),
        .tick_10us (tick_10us)
    );

    ir_tick_select u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .src         (ctrl_q.src),
        .xtal_tick_i (xtal_tick_i),
        .tick_1us    (tick_1us),
        .tick_10us   (tick_10us),
        .tick        (tick)
    );

    ir_phase_engine #(
        .PW (PHASE_W)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctrl_q.en),
        .tick        (tick),
        .shadow_hi   (shadow_hi),
        .shadow_lo   (shadow_lo),
        .phase_high  (phase_high),
        .period_done (period_done_o),
        .act_hi      (act_hi_len),
        .act_lo      (act_lo_len)
    );

    // Carrier follows the phase when enabled, else the idle level
    assign carrier_o = ctrl_q.en ? phase_high : ctrl_q.idle_high;

endmodule

// File: rtl/ir_carrier_chk.sv
// Module: ir_carrier_chk
// Temporal checks on the carrier generator, bound to ir_carrier_gen.
module ir_carrier_chk #(
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_q,
    input logic          carrier_o,
    input logic          period_done_o,
    input logic [PW-1:0] act_hi,
    input logic [PW-1:0] act_lo
);

    // R5
    strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_done_o |=> !period_done_o);

    // R5
    strobe_opens_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_done_o && en_q) |-> carrier_o);

    // R2
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !$past(en_q)) |-> !period_done_o);

    // R3
    enable_starts_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> carrier_o);

    // R7
    hi_len_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q) && !period_done_o) |-> $stable(act_hi));

    // R7
    lo_len_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q) && !period_done_o) |-> $stable(act_lo));

endmodule

bind ir_carrier_gen ir_carrier_chk #(
    .PW (ir_carrier_pkg::PHASE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_q          (ctrl_q.en),
    .carrier_o     (carrier_o),
    .period_done_o (period_done_o),
    .act_hi        (act_hi_len),
    .act_lo        (act_lo_len)
);

// File: tb/ir_carrier_gen_test.sv
module ir_carrier_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_tick_i = 1'b1;
    logic        cfg_ctrl_we = 1'b0;
    logic        cfg_mod_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        carrier_o;
    logic        period_done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ir_carrier_gen #(.SYS_CLK_HZ(4_000_000)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .xtal_tick_i   (xtal_tick_i),
        .cfg_ctrl_we   (cfg_ctrl_we),
        .cfg_mod_we    (cfg_mod_we),
        .cfg_wdata     (cfg_wdata),
        .carrier_o     (carrier_o),
        .period_done_o (period_done_o)
    );

    // Run-length monitor sampled on falling edges
    bit mon_on = 0;
    int hi_runs[$];
    int lo_runs[$];
    int gaps[$];
    int run = 0;
    bit have = 0;
    logic prev = 1'b0;
    int cyc = 0;
    int last_strobe = -1;

    always @(negedge clk) begin
        cyc++;
        if (!mon_on) begin
            run = 0;
            have = 0;
            last_strobe = -1;
        end else begin
            if (have && carrier_o == prev) begin
                run++;
            end else begin
                if (have) begin
                    if (prev) hi_runs.push_back(run);
                    else lo_runs.push_back(run);
                end
                prev = carrier_o;
                run = 1;
                have = 1;
            end
            if (period_done_o) begin
                if (last_strobe >= 0) gaps.push_back(cyc - last_strobe);
                last_strobe = cyc;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        hi_runs.delete();
        lo_runs.delete();
        gaps.delete();
    endtask

    task automatic wr_ctrl(bit en, bit idle, int src);
        @(negedge clk);
        cfg_wdata = '0;
        cfg_wdata[0] = en;
        cfg_wdata[2] = idle;
        cfg_wdata[13:12] = src[1:0];
        cfg_ctrl_we = 1'b1;
        @(posedge clk);
        #1 cfg_ctrl_we = 1'b0;
    endtask

    task automatic wr_mod(int hi, int lo);
        @(negedge clk);
        cfg_wdata = {hi[15:0], lo[15:0]};
        cfg_mod_we = 1'b1;
        @(posedge clk);
        #1 cfg_mod_we = 1'b0;
    endtask

    function automatic int qget(ref int q[$], input int i);
        return (i < q.size()) ? q[i] : -1;
    endfunction

    // Strobe spacing for a tick source with period p (in cycles)
    task automatic src_case(int src, int p, int hi, int lo, string req);
        wr_ctrl(0, 0, src);
        wr_mod(hi, lo);
        wr_ctrl(1, 0, src);
        clear_mon();
        mon_on = 1;
        repeat ((hi + lo + 2) * p * 4) @(negedge clk);
        chk(req, qget(gaps, 0), (hi + lo + 2) * p);
        chk(req, qget(gaps, 1), (hi + lo + 2) * p);
        mon_on = 0;
        wr_ctrl(0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 carrier", int'(carrier_o), 0);
        chk("R1 strobe", int'(period_done_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 carrier after release", int'(carrier_o), 0);

        // R2: idle level follows control bit 2, no strobe
        wr_mod(0, 0);
        wr_ctrl(0, 1, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2 idle high", int'(carrier_o), 1);
            chk("R2 idle strobe", int'(period_done_o), 0);
        end
        wr_ctrl(0, 0, 0);
        @(negedge clk);
        chk("R2 idle low", int'(carrier_o), 0);

        // R3 R4 R5: sweep phase lengths on the system clock tick
        for (int h = 0; h <= 4; h++) begin
            for (int l = 0; l <= 4; l++) begin
                wr_mod(h, l);
                wr_ctrl(1, 0, 0);
                clear_mon();
                mon_on = 1;
                repeat ((h + l + 2) * 3 + 2) @(negedge clk);
                chk("R3 high len p0", qget(hi_runs, 0), h + 1);
                chk("R3 high len p1", qget(hi_runs, 1), h + 1);
                chk("R4 low len p0", qget(lo_runs, 0), l + 1);
                chk("R4 low len p1", qget(lo_runs, 1), l + 1);
                chk("R5 strobe gap", qget(gaps, 0), h + l + 2);
                mon_on = 0;
                wr_ctrl(0, 0, 0);
            end
        end

        // R6: divided tick sources (xtal held high, 4 MHz system clock)
        xtal_tick_i = 1'b1;
        src_case(1, 3, 1, 2, "R6 xtal/3");
        src_case(2, 4, 1, 2, "R6 1us");
        src_case(3, 40, 1, 0, "R6 10us");
        src_case(0, 1, 3, 3, "R6 sysclk");

        // R6: crystal source with no crystal enables does not advance
        xtal_tick_i = 1'b0;
        wr_mod(1, 1);
        wr_ctrl(1, 0, 1);
        clear_mon();
        mon_on = 1;
        repeat (60) @(negedge clk);
        chk("R6 xtal stalled carrier", int'(carrier_o), 1);
        chk("R6 xtal stalled strobes", gaps.size() + lo_runs.size(), 0);
        mon_on = 0;
        wr_ctrl(0, 0, 0);
        xtal_tick_i = 1'b1;

        // R7: reload during a running period lands at the boundary
        wr_mod(3, 2);
        wr_ctrl(1, 0, 0);
        clear_mon();
        mon_on = 1;
        @(negedge clk);
        wr_mod(1, 5);
        repeat (25) @(negedge clk);
        chk("R7 old high kept", qget(hi_runs, 0), 4);
        chk("R7 old low kept", qget(lo_runs, 0), 3);
        chk("R7 new high", qget(hi_runs, 1), 2);
        chk("R7 new low", qget(lo_runs, 1), 6);
        chk("R7 new period", qget(gaps, 0), 8);
        mon_on = 0;
        wr_ctrl(0, 0, 0);

        // R8: disable mid-phase, then re-enable starts a full high phase
        wr_mod(2, 2);
        wr_ctrl(1, 0, 0);
        repeat (2) @(negedge clk);
        wr_ctrl(0, 0, 0);
        @(negedge clk);
        chk("R8 idle after disable", int'(carrier_o), 0);
        wr_ctrl(0, 1, 0);
        @(negedge clk);
        chk("R8 idle high after disable", int'(carrier_o), 1);
        wr_ctrl(1, 1, 0);
        clear_mon();
        mon_on = 1;
        repeat (10) @(negedge clk);
        chk("R8 full high after re-enable", qget(hi_runs, 0), 3);
        chk("R8 low after re-enable", qget(lo_runs, 0), 3);
        mon_on = 0;
        wr_ctrl(0, 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule